// File: doc/BRIEF.md
# Control Endpoint Stage Handshake Controller

This block chooses the handshake that a USB device's control endpoint returns for each decoded token while a control transfer moves through its setup, data and status stages. Firmware steers the data and status stages with two permission bits, data-stage-enable and status. Each bit clears itself once the handshake it allowed has completed. A stall bit forces STALL. A SETUP token ends any earlier transfer, so a new transfer always starts from a clean state.

The packet engine supplies the decoded token events, the transfer direction of the current control request, whether transmit data has been validated, and the host's acknowledgement of packets the device sent. It receives one response code per token, one cycle after the token, together with the data toggle that the next data packet should carry. Firmware writes the three control bits as one word and reads back the status and stall bits. Data-stage-enable always reads back as zero.

Top module: `ctl_ep_handshake`

## Requirements
- R1: After reset, `rsp_valid` is 0, `reg_rdata` is 000 and `data_pid` is 0 (DATA0).
- R2: Every token (`tok_kind` 01 = SETUP, 10 = IN, 11 = OUT, taken while `tok_valid` is 1) gets exactly one response with `rsp_valid` high in the following cycle. The `rsp_code` values are 1 ACK, 2 NAK, 3 STALL, 4 zero-length packet, 5 DATA. A SETUP token is always answered ACK.
- R3: A SETUP token clears the stall, status and data-stage-enable bits and sets `data_pid` to 1 (DATA1).
- R4: With `dir_in` = 1, IN tokens belong to the data stage and OUT tokens to the status stage. With `dir_in` = 0 the roles are swapped. Before the first SETUP, and after a status stage completes, IN and OUT tokens get NAK.
- R5: A data-stage token gets NAK while data-stage-enable is 0. While it is 1, an OUT data token gets ACK. An IN data token gets DATA when `tx_ready` is 1 and NAK when `tx_ready` is 0.
- R6: Data-stage-enable clears itself when an OUT data token is ACKed, or when `host_ack` arrives for a DATA response. Its read-back bit is always 0.
- R7: A status-stage token gets NAK while the status bit is 0. While the status bit is 1, an IN token gets a zero-length packet and an OUT token gets ACK.
- R8: The status bit clears itself when an OUT status token is ACKed, or when `host_ack` arrives for a zero-length packet. The transfer then goes idle.
- R9: With the stall bit at 1 and `ep_iso` at 0, every IN and OUT token gets STALL, overriding all other responses. With `ep_iso` at 1, the stall bit has no effect on responses.
- R10: `data_pid` flips on each ACKed OUT data token and on each `host_ack` of a DATA response. Stalling leaves it unchanged. A rise of `ep_en` after it was low sets it to 0.
- R11: A `fw_wr` pulse loads `fw_wdata` bit 0 into stall, bit 1 into status and bit 2 into data-stage-enable. `reg_rdata` reads {0, status, stall}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | Token type: 01 SETUP, 10 IN, 11 OUT |
| dir_in | input | 1 | Control request reads from the device (data stage uses IN) |
| tx_ready | input | 1 | Transmit data for the data stage has been validated |
| host_ack | input | 1 | Host acknowledged the last packet the device sent |
| ep_iso | input | 1 | Endpoint is isochronous; stall bit is ignored |
| ep_en | input | 1 | Endpoint enable; a low-then-high sequence resets the toggle |
| fw_wr | input | 1 | Firmware write strobe for the control word |
| fw_wdata | input | 3 | Control word: bit 0 stall, bit 1 status, bit 2 data-stage-enable |
| rsp_valid | output | 1 | Response present, one cycle after a token |
| rsp_code | output | 3 | Handshake response code |
| data_pid | output | 1 | Toggle for the next data packet (0 DATA0, 1 DATA1) |
| reg_rdata | output | 3 | Control word read-back |

## Verification
The hardest state to reach from the ports is a cleared enable bit after a completed handshake on the IN side. There the clear waits for a separate host acknowledgement, not for the token. The stimulus therefore first answers an IN data token with DATA and shows that the toggle does not move. It then pulses `host_ack` and shows the toggle flip. A repeated IN token now gets NAK, which proves that data-stage-enable dropped. The toggle-reset path is reached by toggling `ep_en` low and high while the stall bit is set. This separates the effect of stalling from the effect of re-enabling the endpoint.

// File: rtl/ctl_hs_pkg.sv
package ctl_hs_pkg;

  localparam int CW_W     = 3;
  localparam int B_STALL  = 0;
  localparam int B_STATUS = 1;
  localparam int B_DSEN   = 2;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_SETUP = 2'b01,
    TK_IN    = 2'b10,
    TK_OUT   = 2'b11
  } tok_e;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_ACK   = 3'd1,
    RS_NAK   = 3'd2,
    RS_STALL = 3'd3,
    RS_ZLP   = 3'd4,
    RS_DATA  = 3'd5
  } rsp_e;

  typedef enum logic [1:0] {
    PD_NONE = 2'b00,
    PD_DATA = 2'b01,
    PD_ZLP  = 2'b10
  } pend_e;

  // Data stage runs in the direction of the request; status runs opposite.
  function automatic logic is_data_tok(tok_e t, logic dir_in);
    return dir_in ? (t == TK_IN) : (t == TK_OUT);
  endfunction

  function automatic logic is_stat_tok(tok_e t, logic dir_in);
    return dir_in ? (t == TK_OUT) : (t == TK_IN);
  endfunction

  function automatic rsp_e pick_rsp(tok_e t, logic dir_in, logic active,
                                    logic stall, logic iso, logic dsen,
                                    logic status, logic tx_ready);
    rsp_e r;
    r = RS_NONE;
    if (t == TK_SETUP)              r = RS_ACK;
    else if (t == TK_NONE)          r = RS_NONE;
    else if (stall && !iso)         r = RS_STALL;
    else if (!active)               r = RS_NAK;
    else if (is_data_tok(t, dir_in)) begin
      if (!dsen)                    r = RS_NAK;
      else if (t == TK_OUT)         r = RS_ACK;
      else                          r = tx_ready ? RS_DATA : RS_NAK;
    end else begin
      if (!status)                  r = RS_NAK;
      else                          r = (t == TK_IN) ? RS_ZLP : RS_ACK;
    end
    return r;
  endfunction

endpackage

// File: rtl/ctl_hs_regs.sv
module ctl_hs_regs
  import ctl_hs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fw_wr,
  input  logic [CW_W-1:0] fw_wdata,
  input  logic            setup_ev,
  input  logic            dsen_clr,
  input  logic            status_clr,
  output logic            stall_q,
  output logic            status_q,
  output logic            dsen_q,
  output logic [CW_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q  <= 1'b0;
      status_q <= 1'b0;
      dsen_q   <= 1'b0;
    end else if (setup_ev) begin
      stall_q  <= 1'b0;
      status_q <= 1'b0;
      dsen_q   <= 1'b0;
    end else if (fw_wr) begin
      stall_q  <= fw_wdata[B_STALL];
      status_q <= fw_wdata[B_STATUS];
      dsen_q   <= fw_wdata[B_DSEN];
    end else begin
      if (dsen_clr)   dsen_q   <= 1'b0;
      if (status_clr) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[B_STALL]  = stall_q;
    rdata[B_STATUS] = status_q;
  end

  a_r3_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ev |=> (!stall_q && !status_q && !dsen_q));

  a_r6_dsen_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dsen_clr && !fw_wr) |=> !dsen_q);

  a_r8_status_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !fw_wr) |=> !status_q);

endmodule

// File: rtl/ctl_hs_toggle.sv
module ctl_hs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic ep_en,
  input  logic setup_ev,
  input  logic adv_ev,
  output logic pid_q
);

  logic en_prev;
  logic en_rise;

  assign en_rise = ep_en && !en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b1;
      pid_q   <= 1'b0;
    end else begin
      en_prev <= ep_en;
      if (setup_ev)     pid_q <= 1'b1;
      else if (en_rise) pid_q <= 1'b0;
      else if (adv_ev)  pid_q <= ~pid_q;
    end
  end

  a_r10_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_ev && !en_rise && !adv_ev) |=> $stable(pid_q));

  a_r10_reenable_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !setup_ev) |=> !pid_q);

  a_r3_setup_data1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ev |=> pid_q);

endmodule

// File: rtl/ctl_hs_respond.sv
module ctl_hs_respond
  import ctl_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tok_e tk,
  input  rsp_e nxt,
  input  logic host_ack,
  input  logic status_done,
  output logic rsp_valid,
  output rsp_e rsp_q,
  output pend_e pend_q,
  output logic active_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= RS_NONE;
      pend_q    <= PD_NONE;
      active_q  <= 1'b0;
    end else begin
      rsp_valid <= (tk != TK_NONE);
      rsp_q     <= nxt;
      if (tk != TK_NONE)
        pend_q <= (nxt == RS_DATA) ? PD_DATA :
                  (nxt == RS_ZLP)  ? PD_ZLP  : PD_NONE;
      else if (host_ack)
        pend_q <= PD_NONE;
      if (tk == TK_SETUP)   active_q <= 1'b1;
      else if (status_done) active_q <= 1'b0;
    end
  end

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    (tk != TK_NONE) |=> rsp_valid);

  a_r8_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status_done && tk != TK_SETUP) |=> !active_q);

endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
  import ctl_hs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_valid,
  input  logic [1:0]      tok_kind,
  input  logic            dir_in,
  input  logic            tx_ready,
  input  logic            host_ack,
  input  logic            ep_iso,
  input  logic            ep_en,
  input  logic            fw_wr,
  input  logic [CW_W-1:0] fw_wdata,
  output logic            rsp_valid,
  output logic [2:0]      rsp_code,
  output logic            data_pid,
  output logic [CW_W-1:0] reg_rdata
);

  tok_e  tk;
  rsp_e  nxt;
  rsp_e  rsp_q;
  pend_e pend_q;
  logic  active_q, stall_q, status_q, dsen_q;

  // Named internal events
  logic ev_setup, ev_data_out_ack, ev_stat_out_ack;
  logic ev_data_in_done, ev_zlp_done;
  logic dsen_clr, status_done, tog_adv;

  assign tk  = tok_valid ? tok_e'(tok_kind) : TK_NONE;
  assign nxt = pick_rsp(tk, dir_in, active_q, stall_q, ep_iso,
                        dsen_q, status_q, tx_ready);

  assign ev_setup        = (tk == TK_SETUP);
  assign ev_data_out_ack = (tk == TK_OUT) && !dir_in && (nxt == RS_ACK);
  assign ev_stat_out_ack = (tk == TK_OUT) &&  dir_in && (nxt == RS_ACK);
  assign ev_data_in_done = host_ack && (pend_q == PD_DATA);
  assign ev_zlp_done     = host_ack && (pend_q == PD_ZLP);
  assign dsen_clr        = ev_data_out_ack || ev_data_in_done;
  assign status_done     = ev_stat_out_ack || ev_zlp_done;
  assign tog_adv         = ev_data_out_ack || ev_data_in_done;

  ctl_hs_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fw_wr      (fw_wr),
    .fw_wdata   (fw_wdata),
    .setup_ev   (ev_setup),
    .dsen_clr   (dsen_clr),
    .status_clr (status_done),
    .stall_q    (stall_q),
    .status_q   (status_q),
    .dsen_q     (dsen_q),
    .rdata      (reg_rdata)
  );

  ctl_hs_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .ep_en    (ep_en),
    .setup_ev (ev_setup),
    .adv_ev   (tog_adv),
    .pid_q    (data_pid)
  );

  ctl_hs_respond u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .tk          (tk),
    .nxt         (nxt),
    .host_ack    (host_ack),
    .status_done (status_done),
    .rsp_valid   (rsp_valid),
    .rsp_q       (rsp_q),
    .pend_q      (pend_q),
    .active_q    (active_q)
  );

  assign rsp_code = rsp_q;

  a_r2_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup |=> (rsp_valid && rsp_code == RS_ACK));

  a_r9_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((tk == TK_IN || tk == TK_OUT) && stall_q && !ep_iso)
      |=> (rsp_code == RS_STALL));

  a_r5_data_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data_tok(tk, dir_in) && active_q && !dsen_q && !(stall_q && !ep_iso))
      |=> (rsp_code == RS_NAK));

  a_r7_status_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stat_tok(tk, dir_in) && !status_q && !(stall_q && !ep_iso))
      |=> (rsp_code == RS_NAK));

endmodule

// File: tb/sim_ctl_ep_handshake.sv
module sim_ctl_ep_handshake;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'b00;
  logic       dir_in = 1'b0;
  logic       tx_ready = 1'b0;
  logic       host_ack = 1'b0;
  logic       ep_iso = 1'b0;
  logic       ep_en = 1'b1;
  logic       fw_wr = 1'b0;
  logic [2:0] fw_wdata = 3'b000;
  logic       rsp_valid;
  logic [2:0] rsp_code;
  logic       data_pid;
  logic [2:0] reg_rdata;

  localparam logic [1:0] SETUP = 2'b01, TIN = 2'b10, TOUT = 2'b11;
  localparam int ACK = 1, NAK = 2, STALL = 3, ZLP = 4, DATA = 5;

  int n_vec = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ctl_ep_handshake u0 (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .dir_in(dir_in), .tx_ready(tx_ready), .host_ack(host_ack),
    .ep_iso(ep_iso), .ep_en(ep_en), .fw_wr(fw_wr), .fw_wdata(fw_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .data_pid(data_pid),
    .reg_rdata(reg_rdata)
  );

  // Monitor: pops one expected code per response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected response: actual %0d expected none", rsp_code);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (int'(rsp_code) != e) begin
            n_bad++;
            $display("FAIL %s response: actual %0d expected %0d", t, rsp_code, e);
          end
        end
      end
    end
  end

  task automatic send(input logic [1:0] k, input int e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    tok_valid = 1'b1;
    tok_kind  = k;
    @(negedge clk);
    tok_valid = 1'b0;
    tok_kind  = 2'b00;
  endtask

  task automatic fw(input logic [2:0] w);
    @(negedge clk);
    fw_wr = 1'b1;
    fw_wdata = w;
    @(negedge clk);
    fw_wr = 1'b0;
  endtask

  task automatic hack();
    @(negedge clk);
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  task automatic chk(input int act, input int e, input string t);
    n_vec++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid, 0, "R1 rsp_valid");
    chk(reg_rdata, 0, "R1 rdata");
    chk(data_pid, 0, "R1 pid");
    rst_n = 1'b1;
    @(negedge clk);

    // Control OUT transfer
    dir_in = 1'b0;
    send(TOUT, NAK, "R4 idle OUT");
    send(SETUP, ACK, "R2 setup");
    chk(data_pid, 1, "R3 pid DATA1");
    send(TOUT, NAK, "R5 OUT without dsen");
    fw(3'b100);
    chk(reg_rdata, 0, "R6 dsen reads 0");
    send(TOUT, ACK, "R5 OUT data ack");
    chk(data_pid, 0, "R10 toggle on OUT ack");
    send(TOUT, NAK, "R6 dsen cleared after OUT");
    send(TIN, NAK, "R7 status 0 NAK");
    fw(3'b010);
    chk(reg_rdata, 2, "R11 status readback");
    send(TIN, ZLP, "R7 status IN zlp");
    chk(reg_rdata, 2, "R8 status kept until host ack");
    hack();
    chk(reg_rdata, 0, "R8 status cleared by host ack");
    send(TIN, NAK, "R4 idle after status");

    // Control IN transfer
    dir_in = 1'b1;
    send(SETUP, ACK, "R2 setup IN");
    fw(3'b100);
    send(TIN, NAK, "R5 IN without tx_ready");
    tx_ready = 1'b1;
    send(TIN, DATA, "R5 IN data");
    chk(data_pid, 1, "R10 pid waits for host ack");
    hack();
    chk(data_pid, 0, "R10 toggle on host ack");
    send(TIN, NAK, "R6 dsen cleared after host ack");
    tx_ready = 1'b0;
    send(TOUT, NAK, "R7 OUT status NAK");
    fw(3'b010);
    send(TOUT, ACK, "R7 OUT status ack");
    chk(reg_rdata, 0, "R8 status cleared by OUT ack");
    send(TOUT, NAK, "R4 idle after OUT status");

    // Stall
    fw(3'b001);
    chk(reg_rdata, 1, "R11 stall readback");
    send(TIN, STALL, "R9 stall IN");
    send(TOUT, STALL, "R9 stall OUT");
    chk(data_pid, 0, "R10 stall keeps toggle");
    ep_iso = 1'b1;
    send(TIN, NAK, "R9 iso ignores stall");
    ep_iso = 1'b0;
    send(SETUP, ACK, "R2 setup while stalled");
    chk(reg_rdata, 0, "R3 setup clears stall");

    // No data stage: status right after setup
    dir_in = 1'b0;
    fw(3'b011);
    send(TIN, STALL, "R9 stall overrides zlp");
    send(SETUP, ACK, "R2 setup clears all");
    chk(reg_rdata, 0, "R3 setup clears status");
    fw(3'b010);
    send(TIN, ZLP, "R7 no data stage zlp");
    hack();

    // Toggle reset by re-enable
    send(SETUP, ACK, "R2 setup before reenable");
    fw(3'b001);
    chk(data_pid, 1, "R10 stalled pid");
    @(negedge clk); ep_en = 1'b0;
    @(negedge clk); ep_en = 1'b1;
    @(negedge clk);
    chk(data_pid, 0, "R10 reenable resets toggle");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R2 all responses seen");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule